// File: doc/BRIEF.md
# Outstanding Miss Tracker

This block keeps a record of second-level cache misses that are waiting on main memory. Requesters offer a miss, which is a byte address and a source flag. The block drops the low five address bits to form a 27-bit block number. It compares that number with every entry that is in use. If a match is found, the new miss is absorbed: the fill already on its way will serve that requester as well. If no match is found, the lowest-numbered free entry is claimed. When every entry is in use, `full_o` is raised and no new miss is taken until an entry is released.

A claimed entry counts a fixed delay and then presents one request, for one cycle, to the memory request queue. The request carries the block number, the entry index, the source flag and a time stamp of the cycle in which the miss was accepted. A downstream scheduler uses the stamp and the flag for ordering. Memory reports completion with a per-entry bit vector, so several entries may complete in the same cycle. Each completed entry counts a second fixed delay and then becomes ready to fill. Ready entries send their fill notification (block number and index) one per cycle, lowest index first, and each entry is released in the same cycle as its fill.

Top module: `miss_tracker`

## Requirements
- R1: After reset, no entry is in use. `full_o`, `mem_req_valid_o` and `fill_valid_o` are all low.
- R2: A miss is accepted when `miss_valid_i` is high, `full_o` is low and no entry in use holds the same block number (`miss_addr_i[31:5]`). The accepted miss claims the free entry with the lowest index.
- R3: A miss whose block number matches an entry in use is dropped. It claims no entry and produces no memory request.
- R4: `full_o` is high exactly when all 16 entries are in use. While it is high, offered misses are not taken. It falls in the cycle after a fill releases an entry.
- R5: The memory request of an accepted miss is presented exactly 5 cycles after the cycle of acceptance, for one cycle. It carries the block number, the entry index and the source flag (1 = data side, 0 = instruction side).
- R6: `mem_req_stamp_o` holds the value of a cycle counter that advances once per clock. For two requests, the difference of their stamps equals the number of cycles between their acceptances.
- R7: When bit k of `mem_done_i` is high while entry k waits on memory, the fill for entry k comes exactly 5 cycles later if no lower-indexed entry is ready to fill. The fill carries block number and index k, and the entry is released.
- R8: Entries that become ready to fill in the same cycle send their fills in consecutive cycles, in ascending index order.
- R9: A `mem_done_i` bit for an entry that is not waiting on memory has no effect. The entry's request timing is unchanged and no fill follows.
- R10: A miss offered in the same cycle as a fill for the same block is dropped as a duplicate.
- R11: At most one memory request and at most one fill are presented in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| miss_valid_i | input | 1 | A miss is offered this cycle |
| miss_addr_i | input | 32 | Byte address of the miss |
| miss_src_i | input | 1 | Source of the miss: 1 data side, 0 instruction side |
| full_o | output | 1 | All entries in use; requesters must stall |
| mem_req_valid_o | output | 1 | Request to the memory queue this cycle |
| mem_req_blk_o | output | 27 | Block number of the request |
| mem_req_src_o | output | 1 | Source flag of the request |
| mem_req_stamp_o | output | 16 | Cycle stamp of the acceptance |
| mem_req_id_o | output | 4 | Entry index of the request |
| mem_done_i | input | 16 | Per-entry memory completion bits |
| fill_valid_o | output | 1 | Fill notification this cycle |
| fill_blk_o | output | 27 | Block number being filled |
| fill_id_o | output | 4 | Entry index being filled and released |

## Verification
Inputs are driven on the falling edge and outputs are sampled on later falling edges, so counting the falling edges after a stimulus gives the exact cycle in which a result is due. A memory request is checked on the fifth falling edge after the acceptance cycle. A fill is checked on the fifth falling edge after its completion bit, plus one more edge for each lower index that fills first. `full_o` is checked on the edge after a release. Windows in which nothing may appear are checked edge by edge for their whole length. This shows that a dropped miss or an ignored completion bit leaves no mark, and that a result neither comes early nor is delayed.

// File: rtl/miss_tracker_pkg.sv
package miss_tracker_pkg;
  typedef enum logic [2:0] {
    ENT_IDLE,
    ENT_ISSUE,   // counting down to memory request
    ENT_MEM,     // waiting on memory completion
    ENT_FILL,    // counting down to fill
    ENT_RDY      // fill pending arbitration
  } ent_state_e;
endpackage

// File: rtl/mt_prio.sv
module mt_prio #(
  parameter int N    = 16,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = IW'(i);
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/mt_entry.sv
module mt_entry
  import miss_tracker_pkg::*;
#(
  parameter int BLK_W     = 27,
  parameter int STAMP_W   = 16,
  parameter int ISSUE_DLY = 5,
  parameter int FILL_DLY  = 5,
  localparam int MAXD     = (ISSUE_DLY > FILL_DLY) ? ISSUE_DLY : FILL_DLY,
  localparam int CNT_W    = $clog2(MAXD + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               alloc_i,
  input  logic [BLK_W-1:0]   blk_i,
  input  logic               src_i,
  input  logic [STAMP_W-1:0] stamp_i,
  input  logic               done_i,
  input  logic               grant_i,
  output logic               valid_o,
  output logic [BLK_W-1:0]   blk_o,
  output logic               src_o,
  output logic [STAMP_W-1:0] stamp_o,
  output logic               issue_o,
  output logic               fill_pend_o
);
  ent_state_e         state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BLK_W-1:0]   blk_q;
  logic               src_q;
  logic [STAMP_W-1:0] stamp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENT_IDLE;
      cnt_q   <= '0;
      blk_q   <= '0;
      src_q   <= 1'b0;
      stamp_q <= '0;
    end else begin
      unique case (state_q)
        ENT_IDLE: if (alloc_i) begin
          state_q <= ENT_ISSUE;
          cnt_q   <= CNT_W'(ISSUE_DLY - 1);
          blk_q   <= blk_i;
          src_q   <= src_i;
          stamp_q <= stamp_i;
        end
        ENT_ISSUE: begin
          if (cnt_q == '0) state_q <= ENT_MEM;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ENT_MEM: if (done_i) begin
          state_q <= ENT_FILL;
          cnt_q   <= CNT_W'(FILL_DLY - 1);
        end
        ENT_FILL: begin
          if (cnt_q == '0) state_q <= grant_i ? ENT_IDLE : ENT_RDY;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ENT_RDY: if (grant_i) state_q <= ENT_IDLE;
        default: state_q <= ENT_IDLE;
      endcase
    end
  end

  assign valid_o     = (state_q != ENT_IDLE);
  assign blk_o       = blk_q;
  assign src_o       = src_q;
  assign stamp_o     = stamp_q;
  assign issue_o     = (state_q == ENT_ISSUE) && (cnt_q == '0);
  assign fill_pend_o = ((state_q == ENT_FILL) && (cnt_q == '0)) || (state_q == ENT_RDY);

  // R2
  alloc_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !valid_o);
  // R5
  issue_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |=> !issue_o);
  // R7
  free_after_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |=> !valid_o);
  // R8
  grant_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> fill_pend_o);
  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && done_i && !alloc_i) |=> !valid_o);
endmodule

// File: rtl/miss_tracker.sv
module miss_tracker #(
  parameter int NUM_ENT   = 16,
  parameter int ADDR_W    = 32,
  parameter int OFS_W     = 5,
  parameter int ISSUE_DLY = 5,
  parameter int FILL_DLY  = 5,
  parameter int STAMP_W   = 16,
  localparam int BLK_W    = ADDR_W - OFS_W,
  localparam int IDX_W    = $clog2(NUM_ENT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               miss_valid_i,
  input  logic [ADDR_W-1:0]  miss_addr_i,
  input  logic               miss_src_i,
  output logic               full_o,
  output logic               mem_req_valid_o,
  output logic [BLK_W-1:0]   mem_req_blk_o,
  output logic               mem_req_src_o,
  output logic [STAMP_W-1:0] mem_req_stamp_o,
  output logic [IDX_W-1:0]   mem_req_id_o,
  input  logic [NUM_ENT-1:0] mem_done_i,
  output logic               fill_valid_o,
  output logic [BLK_W-1:0]   fill_blk_o,
  output logic [IDX_W-1:0]   fill_id_o
);
  logic [BLK_W-1:0]   miss_blk;
  logic               unused_ofs;
  logic [STAMP_W-1:0] cyc_q;

  logic [NUM_ENT-1:0] ent_valid, ent_issue, ent_pend, ent_match;
  logic [NUM_ENT-1:0] free_gnt, alloc_vec, fill_gnt;
  logic [BLK_W-1:0]   ent_blk   [NUM_ENT];
  logic               ent_src   [NUM_ENT];
  logic [STAMP_W-1:0] ent_stamp [NUM_ENT];
  logic [IDX_W-1:0]   unused_free_idx;
  logic               free_any, hit, accept;

  assign miss_blk   = miss_addr_i[ADDR_W-1:OFS_W];
  assign unused_ofs = ^miss_addr_i[OFS_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else         cyc_q <= cyc_q + 1'b1;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_ENT; g++) begin : g_ent
      mt_entry #(
        .BLK_W    (BLK_W),
        .STAMP_W  (STAMP_W),
        .ISSUE_DLY(ISSUE_DLY),
        .FILL_DLY (FILL_DLY)
      ) u_ent (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .alloc_i    (alloc_vec[g]),
        .blk_i      (miss_blk),
        .src_i      (miss_src_i),
        .stamp_i    (cyc_q),
        .done_i     (mem_done_i[g]),
        .grant_i    (fill_gnt[g]),
        .valid_o    (ent_valid[g]),
        .blk_o      (ent_blk[g]),
        .src_o      (ent_src[g]),
        .stamp_o    (ent_stamp[g]),
        .issue_o    (ent_issue[g]),
        .fill_pend_o(ent_pend[g])
      );
      assign ent_match[g] = ent_valid[g] && (ent_blk[g] == miss_blk);
    end
  endgenerate

  assign hit    = |ent_match;
  assign full_o = &ent_valid;
  assign accept = miss_valid_i && !full_o && !hit;

  mt_prio #(.N(NUM_ENT)) u_free_pick (
    .req_i(~ent_valid),
    .gnt_o(free_gnt),
    .idx_o(unused_free_idx),
    .any_o(free_any)
  );
  assign alloc_vec = (accept && free_any) ? free_gnt : '0;

  mt_prio #(.N(NUM_ENT)) u_fill_pick (
    .req_i(ent_pend),
    .gnt_o(fill_gnt),
    .idx_o(fill_id_o),
    .any_o(fill_valid_o)
  );

  always_comb begin
    mem_req_blk_o   = '0;
    mem_req_src_o   = 1'b0;
    mem_req_stamp_o = '0;
    mem_req_id_o    = '0;
    fill_blk_o      = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (ent_issue[i]) begin
        mem_req_blk_o   = ent_blk[i];
        mem_req_src_o   = ent_src[i];
        mem_req_stamp_o = ent_stamp[i];
        mem_req_id_o    = IDX_W'(i);
      end
      if (fill_gnt[i]) fill_blk_o = ent_blk[i];
    end
  end
  assign mem_req_valid_o = |ent_issue;

  // R11
  one_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ent_issue));
  // R4
  full_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (alloc_vec == '0));
  // R3
  dup_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && hit) |-> (alloc_vec == '0));
  // R2
  one_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(alloc_vec));
  // R7
  fill_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |=> !full_o);
endmodule

// File: tb/miss_tracker_bench.sv
module miss_tracker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_addr = '0;
  logic        miss_src = 1'b0;
  logic [15:0] mem_done = '0;
  logic        full, req_valid, req_src, fill_valid;
  logic [26:0] req_blk, fill_blk;
  logic [15:0] req_stamp;
  logic [3:0]  req_id, fill_id;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  miss_tracker u_miss_tracker (
    .clk_i(clk), .rst_ni(rst_n),
    .miss_valid_i(miss_valid), .miss_addr_i(miss_addr), .miss_src_i(miss_src),
    .full_o(full),
    .mem_req_valid_o(req_valid), .mem_req_blk_o(req_blk), .mem_req_src_o(req_src),
    .mem_req_stamp_o(req_stamp), .mem_req_id_o(req_id),
    .mem_done_i(mem_done),
    .fill_valid_o(fill_valid), .fill_blk_o(fill_blk), .fill_id_o(fill_id)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        src;
    logic        exp_req;
    logic [3:0]  exp_id;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{addr: 32'h1000_0000, src: 1'b1, exp_req: 1'b1, exp_id: 4'd0},
    '{addr: 32'h1000_001F, src: 1'b0, exp_req: 1'b0, exp_id: 4'd0},
    '{addr: 32'h2000_0040, src: 1'b0, exp_req: 1'b1, exp_id: 4'd1},
    '{addr: 32'h1000_0020, src: 1'b1, exp_req: 1'b1, exp_id: 4'd2},
    '{addr: 32'h2000_0044, src: 1'b1, exp_req: 1'b0, exp_id: 4'd0}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive a miss at the current falling edge, check the request five cycles later
  task automatic miss_and_check(input logic [31:0] addr, input logic src, input logic exp_req,
                                input logic [3:0] exp_id, input string tag,
                                output logic [15:0] stamp, output int t0);
    bit early;
    miss_valid = 1'b1; miss_addr = addr; miss_src = src;
    t0 = cyc;
    @(negedge clk);
    miss_valid = 1'b0;
    early = 0;
    if (req_valid) early = 1;
    for (int k = 2; k < 5; k++) begin
      @(negedge clk);
      if (req_valid) early = 1;
    end
    @(negedge clk);
    chk(!early, {tag, " no early request"}, 64'(early), 64'd0);
    chk(req_valid == exp_req, {tag, " request valid"}, 64'(req_valid), 64'(exp_req));
    if (exp_req) begin
      chk(req_id == exp_id, {tag, " request id"}, 64'(req_id), 64'(exp_id));
      chk(req_blk == addr[31:5], {tag, " request block"}, 64'(req_blk), 64'(addr[31:5]));
      chk(req_src == src, {tag, " request source"}, 64'(req_src), 64'(src));
    end
    stamp = req_stamp;
  endtask

  initial begin
    logic [15:0] st0, st1, st_x;
    int c0, c1, c_x;
    bit seen;

    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!full && !req_valid && !fill_valid, "R1 outputs in reset", {full, req_valid, fill_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!full && !req_valid && !fill_valid, "R1 outputs after reset", {full, req_valid, fill_valid}, 0);

    // table: R2 allocation, R3 duplicates, R5 request timing
    foreach (VECS[i]) begin
      miss_and_check(VECS[i].addr, VECS[i].src, VECS[i].exp_req, VECS[i].exp_id,
                     VECS[i].exp_req ? "R2 R5 vector" : "R3 vector", st_x, c_x);
      if (i == 0) begin st0 = st_x; c0 = c_x; end
      @(negedge clk);
    end

    // R7 fill timing for entry 1
    mem_done = 16'h0002;
    @(negedge clk);
    mem_done = '0;
    seen = 0;
    if (fill_valid) seen = 1;
    for (int k = 2; k < 5; k++) begin @(negedge clk); if (fill_valid) seen = 1; end
    @(negedge clk);
    chk(!seen, "R7 no early fill", 64'(seen), 0);
    chk(fill_valid && fill_id == 4'd1, "R7 fill id", {fill_valid, fill_id}, {1'b1, 4'd1});
    chk(fill_blk == 27'(32'h2000_0040 >> 5), "R7 fill block", 64'(fill_blk), 64'(32'h2000_0040 >> 5));
    @(negedge clk);

    // R2 lowest free entry reused, R6 stamp spacing
    miss_and_check(32'h3000_0000, 1'b1, 1'b1, 4'd1, "R2 reuse", st1, c1);
    chk(16'(st1 - st0) == 16'(c1 - c0), "R6 stamp spacing", 64'(16'(st1 - st0)), 64'(16'(c1 - c0)));
    @(negedge clk);

    // R4 fill all entries: ids 3..15
    for (int k = 0; k < 13; k++) begin
      miss_valid = 1'b1; miss_addr = 32'h4000_0000 + 32'(k * 32); miss_src = 1'b0;
      @(negedge clk);
    end
    miss_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk(full, "R4 full asserted", 64'(full), 1);
    miss_and_check(32'h5000_0000, 1'b1, 1'b0, 4'd0, "R4 miss while full", st_x, c_x);
    chk(full, "R4 full held", 64'(full), 1);
    @(negedge clk);

    // R8 three completions in one cycle, serialized ascending
    mem_done = 16'h0038;
    @(negedge clk);
    mem_done = '0;
    repeat (3) @(negedge clk);
    chk(!fill_valid, "R8 no fill before delay", 64'(fill_valid), 0);
    @(negedge clk);
    chk(fill_valid && fill_id == 4'd3, "R8 first fill", {fill_valid, fill_id}, {1'b1, 4'd3});
    chk(fill_blk == 27'(32'h4000_0000 >> 5), "R8 first block", 64'(fill_blk), 64'(32'h4000_0000 >> 5));
    @(negedge clk);
    chk(fill_valid && fill_id == 4'd4, "R8 second fill", {fill_valid, fill_id}, {1'b1, 4'd4});
    chk(!full, "R4 full released", 64'(full), 0);
    @(negedge clk);
    chk(fill_valid && fill_id == 4'd5, "R8 third fill", {fill_valid, fill_id}, {1'b1, 4'd5});
    chk(fill_blk == 27'(32'h4000_0040 >> 5), "R8 third block", 64'(fill_blk), 64'(32'h4000_0040 >> 5));
    // R10 miss to the block being filled this cycle
    miss_and_check(32'h4000_0040, 1'b1, 1'b0, 4'd0, "R10 same-cycle fill", st_x, c_x);
    @(negedge clk);

    // R9 done for an entry still counting to issue
    miss_valid = 1'b1; miss_addr = 32'h6000_0000; miss_src = 1'b0;
    @(negedge clk);
    miss_valid = 1'b0;
    mem_done = 16'h0008;
    @(negedge clk);
    mem_done = '0;
    repeat (2) @(negedge clk);
    @(negedge clk);
    chk(req_valid && req_id == 4'd3, "R9 request unaffected", {req_valid, req_id}, {1'b1, 4'd3});
    seen = 0;
    for (int k = 0; k < 8; k++) begin @(negedge clk); if (fill_valid) seen = 1; end
    chk(!seen, "R9 no fill from ignored done", 64'(seen), 0);

    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule